// File: doc/BRIEF.md
# Randomized Buffer Accumulation Engine

This block adds one signed or unsigned 16-bit sample into several words of a sensing buffer. The buffer sits in a word-addressed data memory. The words are picked pseudo-randomly, and no index table is stored anywhere. A single start strobe carries the buffer base address and the sample. The engine then runs a configured number of read-modify-write iterations, one per clock cycle. In each iteration it takes the low bits of an internal 16-bit shift-register generator as the index, adds that index to the base, and writes the memory word plus the sample back to the same address.

Reads and writes overlap. The read for one iteration is issued in the same cycle as the write of the previous iteration. When two consecutive iterations hit the same word, the pending sum is forwarded to the adder, so that word receives the sample twice. Software programs four settings through a small write-only register port: the feedback polynomial, the generator state (seed), the index width and the repeat count. The generator state carries over from one command to the next.

Top module: `rand_accum_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_re` and `mem_we` are low. The settings are polynomial 16'h002D, generator state 16'hACE1, index width 8 and repeat count 12.
- R2: Every iteration reads address A = (base + index) mod 2^16 and, one cycle later, writes A with (old word + sample) mod 2^16.
- R3: A command performs exactly as many reads and writes as the repeat count. A repeat count of 0 performs no memory access and still pulses `done`.
- R4: The index is the IB low bits of the generator state, where IB is the index width. After each read issue the state advances IB single steps. One step computes the parity of (state AND polynomial), shifts the state right by one and inserts the parity at bit 15.
- R5: A written index width of 0 is taken as 1, and a written value above 16 is taken as 16.
- R6: Take the cycle in which start is accepted as cycle 0. Reads are issued in cycles 1..I, and each write follows its read by one cycle. `done` is high for exactly cycle I+2, which is cycle 1 when I = 0. `busy` is high from cycle 1 through the `done` cycle, and no memory access occurs while `busy` is low.
- R7: When two consecutive iterations use the same address, the second write holds the first write's value plus the sample, so the sample is added twice.
- R8: A start strobe while `busy` is high is ignored: it starts no command and changes neither the base nor the sample in use.
- R9: Setting writes use `cfg_sel` codes 0 = polynomial, 1 = generator state, 2 = index width, 3 = repeat count (low 8 bits). Setting writes while `busy` is high are ignored.
- R10: Writing the generator state sets the state used for the next index. Without such a write, the state continues from where the previous command left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting select code |
| cfg_wdata | input | 16 | Setting write value |
| start | input | 1 | Command strobe |
| base | input | 16 | Buffer base address for the command |
| sample | input | 16 | Sample to accumulate |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_re | output | 1 | Memory read enable |
| mem_raddr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Memory write data |

## Verification
The bound checker watches the properties that hold on every cycle:
- each read is followed by a write to the same address;
- the offset of each read stays inside the window the index width allows;
- `done` lasts one cycle;
- the memory stays silent while idle;
- the captured base and sample hold steady while busy;
- back-to-back hits on one word accumulate the sample twice.

Only the bench's scenarios can show the rest. These are the exact random address sequence under each polynomial, seed and width setting; the resulting memory sums, including wrap of the address and of the sum; the cycle count for each repeat count; and the fact that starts and setting writes during a run are ignored.

// File: rtl/rae_pkg.sv
package rae_pkg;

  typedef enum logic [1:0] {
    CFG_POLY  = 2'd0,
    CFG_SEED  = 2'd1,
    CFG_IBITS = 2'd2,
    CFG_REPS  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/rae_cfg_regs.sv
module rae_cfg_regs
  import rae_pkg::*;
#(
  parameter int unsigned SW  = 16,
  parameter int unsigned CW  = 8,
  parameter int unsigned IBW = 5,
  parameter logic [SW-1:0]  POLY_RST = 16'h002D,
  parameter logic [IBW-1:0] IB_RST   = 5'd8,
  parameter logic [CW-1:0]  REPS_RST = 8'd12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [SW-1:0]  cfg_wdata,
  input  logic           busy,
  output logic [SW-1:0]  poly,
  output logic [IBW-1:0] ib,
  output logic [CW-1:0]  reps,
  output logic           seed_load,
  output logic [SW-1:0]  seed_val
);

  localparam logic [SW-1:0]  IB_MAX_W = SW'(SW);
  localparam logic [IBW-1:0] IB_MAX   = IBW'(SW);
  localparam logic [IBW-1:0] IB_MIN   = IBW'(1);

  cfg_sel_e       sel;
  logic           wr_ok;
  logic [IBW-1:0] ib_sat;
  logic [SW-1:0]  poly_q, poly_d;
  logic [IBW-1:0] ib_q, ib_d;
  logic [CW-1:0]  reps_q, reps_d;

  assign sel   = cfg_sel_e'(cfg_sel);
  assign wr_ok = cfg_we & ~busy;

  // saturate the width to 1..SW on the full written value
  always_comb begin
    if (cfg_wdata == '0)           ib_sat = IB_MIN;
    else if (cfg_wdata > IB_MAX_W) ib_sat = IB_MAX;
    else                           ib_sat = cfg_wdata[IBW-1:0];
  end

  always_comb begin
    poly_d = poly_q;
    ib_d   = ib_q;
    reps_d = reps_q;
    if (wr_ok) begin
      unique case (sel)
        CFG_POLY:  poly_d = cfg_wdata;
        CFG_IBITS: ib_d   = ib_sat;
        CFG_REPS:  reps_d = cfg_wdata[CW-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q <= POLY_RST;
      ib_q   <= IB_RST;
      reps_q <= REPS_RST;
    end else begin
      poly_q <= poly_d;
      ib_q   <= ib_d;
      reps_q <= reps_d;
    end
  end

  assign poly      = poly_q;
  assign ib        = ib_q;
  assign reps      = reps_q;
  assign seed_load = wr_ok && (sel == CFG_SEED);
  assign seed_val  = cfg_wdata;

endmodule

// File: rtl/rae_index_gen.sv
module rae_index_gen #(
  parameter int unsigned   SW       = 16,
  parameter int unsigned   IBW      = 5,
  parameter logic [SW-1:0] SEED_RST = 16'hACE1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [SW-1:0]  load_val,
  input  logic           adv,
  input  logic [SW-1:0]  poly,
  input  logic [IBW-1:0] ib,
  output logic [SW-1:0]  index
);

  logic [SW-1:0] st_q, st_d;
  logic [SW-1:0] chain [0:SW];

  // unrolled chain of single steps; the tap picks step count ib
  assign chain[0] = st_q;
  for (genvar k = 0; k < SW; k++) begin : g_step
    assign chain[k+1] = {^(chain[k] & poly), chain[k][SW-1:1]};
  end

  // keep only the ib low state bits
  for (genvar j = 0; j < SW; j++) begin : g_mask
    localparam logic [IBW-1:0] JV = IBW'(j);
    assign index[j] = st_q[j] & (JV < ib);
  end

  always_comb begin
    st_d = st_q;
    if (load)     st_d = load_val;
    else if (adv) st_d = chain[ib];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED_RST;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/rae_sequencer.sv
module rae_sequencer
  import rae_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] reps,
  output logic          accept,
  output logic          issue,
  output logic          busy,
  output logic          done
);

  localparam logic [CW-1:0] ONE = CW'(1);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] rem_q, rem_d;

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    accept = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          rem_d  = reps;
          st_d   = (reps == '0) ? ST_FIN : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        rem_d = rem_q - ONE;
        if (rem_q == ONE) st_d = ST_DRAIN;
      end
      ST_DRAIN: st_d = ST_FIN;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
    end
  end

  assign issue = (st_q == ST_ISSUE);
  assign busy  = (st_q != ST_IDLE);
  assign done  = (st_q == ST_FIN);

endmodule

// File: rtl/rae_accum_path.sv
module rae_accum_path #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] base_in,
  input  logic [DW-1:0] sample_in,
  input  logic          issue,
  input  logic [AW-1:0] index,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] base_q,
  output logic [DW-1:0] sample_q
);

  logic [AW-1:0] base_d;
  logic [DW-1:0] sample_d;
  logic          b_vld_q, b_vld_d;
  logic [AW-1:0] b_addr_q, b_addr_d;
  logic          lw_vld_q, lw_vld_d;
  logic [AW-1:0] lw_addr_q, lw_addr_d;
  logic [DW-1:0] lw_data_q, lw_data_d;
  logic [AW-1:0] raddr;
  logic          fwd;
  logic [DW-1:0] opnd, sum;

  // address wraps in the AW-bit space
  assign raddr = base_q + index;

  // the write one cycle back was not yet visible to the read now returning
  assign fwd  = lw_vld_q && (lw_addr_q == b_addr_q);
  assign opnd = fwd ? lw_data_q : mem_rdata;
  assign sum  = opnd + sample_q;

  always_comb begin
    base_d    = base_q;
    sample_d  = sample_q;
    b_addr_d  = b_addr_q;
    lw_addr_d = lw_addr_q;
    lw_data_d = lw_data_q;
    if (accept) begin
      base_d   = base_in;
      sample_d = sample_in;
    end
    b_vld_d = issue;
    if (issue) b_addr_d = raddr;
    lw_vld_d = b_vld_q;
    if (b_vld_q) begin
      lw_addr_d = b_addr_q;
      lw_data_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      sample_q  <= '0;
      b_vld_q   <= 1'b0;
      b_addr_q  <= '0;
      lw_vld_q  <= 1'b0;
      lw_addr_q <= '0;
      lw_data_q <= '0;
    end else begin
      base_q    <= base_d;
      sample_q  <= sample_d;
      b_vld_q   <= b_vld_d;
      b_addr_q  <= b_addr_d;
      lw_vld_q  <= lw_vld_d;
      lw_addr_q <= lw_addr_d;
      lw_data_q <= lw_data_d;
    end
  end

  assign mem_re    = issue;
  assign mem_raddr = raddr;
  assign mem_we    = b_vld_q;
  assign mem_waddr = b_addr_q;
  assign mem_wdata = sum;

endmodule

// File: rtl/rand_accum_engine.sv
module rand_accum_engine #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [SW-1:0] cfg_wdata,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] sample,
  output logic          busy,
  output logic          done,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);

  localparam int unsigned IBW = $clog2(SW + 1);

  logic [SW-1:0]  poly;
  logic [IBW-1:0] ib_eff;
  logic [CW-1:0]  reps;
  logic           seed_load;
  logic [SW-1:0]  seed_val;
  logic           accept, issue;
  logic [SW-1:0]  index;
  logic [AW-1:0]  base_q;
  logic [DW-1:0]  sample_q;

  rae_cfg_regs #(
    .SW(SW), .CW(CW), .IBW(IBW),
    .POLY_RST(SW'(16'h002D)), .IB_RST(IBW'(8)), .REPS_RST(CW'(12))
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .busy(busy),
    .poly(poly), .ib(ib_eff), .reps(reps),
    .seed_load(seed_load), .seed_val(seed_val)
  );

  rae_index_gen #(
    .SW(SW), .IBW(IBW), .SEED_RST(SW'(16'hACE1))
  ) u_gen (
    .clk(clk), .rst_n(rst_n),
    .load(seed_load), .load_val(seed_val),
    .adv(issue), .poly(poly), .ib(ib_eff),
    .index(index)
  );

  rae_sequencer #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .reps(reps),
    .accept(accept), .issue(issue), .busy(busy), .done(done)
  );

  rae_accum_path #(.AW(AW), .DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .base_in(base), .sample_in(sample),
    .issue(issue), .index(AW'(index)),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .base_q(base_q), .sample_q(sample_q)
  );

endmodule

// File: rtl/rae_checker.sv
module rae_checker #(
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 16,
  parameter int unsigned IBW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           mem_re,
  input logic [AW-1:0]  mem_raddr,
  input logic           mem_we,
  input logic [AW-1:0]  mem_waddr,
  input logic [DW-1:0]  mem_wdata,
  input logic [AW-1:0]  base_q,
  input logic [DW-1:0]  sample_q,
  input logic [IBW-1:0] ib_eff
);

  logic [AW-1:0] offs;
  assign offs = mem_raddr - base_q;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_re && !mem_we));

  p_write_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_we && mem_waddr == $past(mem_raddr)));

  p_index_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> ((offs >> ib_eff) == '0));

  p_width_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_eff >= IBW'(1)) && (ib_eff <= IBW'(AW)));

  p_busy_holds_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(base_q) && $stable(sample_q)));

  p_double_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && mem_waddr == $past(mem_waddr))
      |-> (mem_wdata == DW'($past(mem_wdata) + sample_q)));

endmodule

bind rand_accum_engine rae_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_re(mem_re), .mem_raddr(mem_raddr),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
  .base_q(base_q), .sample_q(sample_q), .ib_eff(ib_eff)
);

// File: tb/sim_rand_accum_engine.sv
`timescale 1ns/1ps
module sim_rand_accum_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic        start;
  logic [15:0] base, sample;
  logic        busy, done, mem_re, mem_we;
  logic [15:0] mem_raddr, mem_rdata, mem_waddr, mem_wdata;

  always #4 clk = ~clk;

  rand_accum_engine u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .start(start), .base(base), .sample(sample),
    .busy(busy), .done(done),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  // memory model (1024 words, addresses alias on the low 10 bits)
  logic [15:0] mem     [0:1023];
  logic [15:0] ref_mem [0:1023];

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_raddr[9:0]];
    if (mem_we) mem[mem_waddr[9:0]] <= mem_wdata;
  end

  // reference state
  logic [15:0] m_poly, m_state;
  int          m_ib, m_reps;
  int          n_chk = 0, n_bad = 0, n_rd = 0, n_repeat = 0;
  bit          finished = 1'b0;
  logic [31:0] exp_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [15:0] step_n(input logic [15:0] s, input logic [15:0] p, input int n);
    logic [15:0] t = s;
    for (int k = 0; k < n; k++) t = {^(t & p), t[15:1]};
    return t;
  endfunction

  function automatic logic [15:0] low_mask(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (mem_re) n_rd++;
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R8", "unexpected write", {mem_waddr, mem_wdata}, 32'h0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check({mem_waddr, mem_wdata} == e, "R2/R4/R7", "write addr,data",
                {mem_waddr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: m_poly  = val;
      2'd1: m_state = val;
      2'd2: m_ib    = (val == 0) ? 1 : ((val > 16) ? 16 : int'(val));
      default: m_reps = int'(val[7:0]);
    endcase
  endtask

  // poke: 0 none, 1 start while busy (R8), 2 setting write while busy (R9)
  task automatic run_cmd(input logic [15:0] b, input logic [15:0] s, input int poke);
    int cyc, exp_cyc;
    logic [15:0] a, prev;
    prev = 16'h0;
    for (int it = 0; it < m_reps; it++) begin
      a = b + (m_state & low_mask(m_ib));
      ref_mem[a[9:0]] = ref_mem[a[9:0]] + s;
      exp_q.push_back({a, ref_mem[a[9:0]]});
      if (it > 0 && a == prev) n_repeat++;
      prev = a;
      m_state = step_n(m_state, m_poly, m_ib);
    end
    exp_cyc = (m_reps == 0) ? 1 : m_reps + 2;
    @(negedge clk);
    n_rd = 0;
    start = 1'b1; base = b; sample = s;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    forever begin
      if (done || cyc > 2000) break;
      if (cyc == 2 && poke == 1) begin
        start = 1'b1; base = b ^ 16'h0F0F; sample = 16'h7777;
      end else if (cyc == 2 && poke == 2) begin
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h1234;
      end else begin
        start = 1'b0; cfg_we = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; cfg_we = 1'b0;
    check(cyc == exp_cyc, "R6", "cycles from accept to done", cyc, exp_cyc);
    check(busy == 1'b1, "R6", "busy during done", {31'd0, busy}, 32'd1);
    @(negedge clk);
    check(!done && !busy, "R6", "done single pulse then idle", {30'd0, done, busy}, 32'd0);
    check(exp_q.size() == 0, "R3", "writes left over", exp_q.size(), 32'd0);
    check(n_rd == m_reps, "R3", "read count", n_rd, m_reps);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 16'(i * 7);
      ref_mem[i] = 16'(i * 7);
    end
    m_poly = 16'h002D; m_state = 16'hACE1; m_ib = 8; m_reps = 12;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 16'h0;
    start = 1'b0; base = 16'h0; sample = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_re && !mem_we, "R1", "reset outputs",
          {28'd0, busy, done, mem_re, mem_we}, 32'd0);

    // R1: defaults drive the first command
    run_cmd(16'h0100, 16'h0005, 0);
    // R8: start while busy ignored
    run_cmd(16'h0100, 16'h0003, 1);
    // R4 with a narrow width and longer run
    cfg_write(2'd2, 16'd4); cfg_write(2'd3, 16'd20);
    run_cmd(16'h0200, 16'h1111, 0);
    // R7: width 1 forces back-to-back repeats
    cfg_write(2'd2, 16'd1); cfg_write(2'd3, 16'd30);
    run_cmd(16'h0300, 16'h0101, 0);
    check(n_repeat > 0, "R7", "back-to-back repeats exercised", n_repeat, 32'd1);
    // R5: saturation low and high
    cfg_write(2'd2, 16'd0); cfg_write(2'd3, 16'd5);
    run_cmd(16'h0080, 16'h0202, 0);
    cfg_write(2'd2, 16'd40); cfg_write(2'd3, 16'd10);
    run_cmd(16'h0000, 16'h0033, 0);
    // R2: address and sum wrap
    cfg_write(2'd2, 16'd8); cfg_write(2'd3, 16'd16);
    run_cmd(16'hFFF0, 16'hFFFF, 0);
    run_cmd(16'hFFF0, 16'h8000, 0);
    // R3: zero repeat count
    cfg_write(2'd3, 16'd0);
    run_cmd(16'h0100, 16'h0001, 0);
    // R9: setting write during a run ignored (model keeps old polynomial)
    cfg_write(2'd3, 16'd6);
    run_cmd(16'h0140, 16'h0044, 2);
    run_cmd(16'h0140, 16'h0045, 0);
    // R10: new polynomial and seed take effect; state then carries over
    cfg_write(2'd0, 16'h8016); cfg_write(2'd1, 16'h0001);
    cfg_write(2'd2, 16'd6);
    run_cmd(16'h0180, 16'h0099, 0);
    run_cmd(16'h0180, 16'h0100, 0);
    repeat (3) @(negedge clk);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R6", "watchdog expired", 32'd0, 32'd1);
    report();
  end

endmodule